// File: doc/BRIEF.md
# Decimating ADC Sample Packer

This block sits behind a pair of 12-bit converter streams that have already been brought into the acquisition clock domain. On each cycle where `smp_vld` is high, a pair of samples (one per channel) is offered. A programmable decimation count keeps one pair out of every `div+1` offered pairs and drops the rest. The kept samples are gathered into 96-bit words of eight 12-bit slots for the trigger and memory-writer stage that follows.

Three packing layouts are selectable. Single-channel mode packs only channel 1. Dual-channel mode gives each channel half of the word. Dual-sample mode is used when the two converters sample the same signal on opposite clock phases: the two channels are merged alternately into one stream at twice the rate. The acquisition window length follows from: kept samples × sample period × (div+1) = screen divisions × time per division. `mode` and `div` are changed only while idle, and a synchronous `clr` is applied after each change.

Top module: `adc_packer`

## Requirements
- R1: While `rst_n` is low, `word_vld` is 0 and `word` is all zeros.
- R2: After reset or `clr`, the first pair offered with `smp_vld` high is kept. After that, one pair out of every `div+1` offered pairs is kept. Cycles with `smp_vld` low do not advance the decimation count.
- R3: With `mode` = 0 (and also with `mode` = 3), eight kept channel-1 samples fill one word. The k-th kept sample (k = 0..7) occupies bits [12k+11:12k], so the earliest sample is in [11:0].
- R4: With `mode` = 1, four kept pairs fill one word. Kept pair k (k = 0..3) places channel 1 in slot k and channel 2 in slot k+4, so channel 1 fills the lower 48 bits.
- R5: With `mode` = 2, four kept pairs fill one word. Kept pair k places channel 1 in slot 2k and channel 2 in slot 2k+1, so the slot order from the bottom is ch1, ch2, ch1, ch2, and so on.
- R6: `word_vld` rises in the cycle after the edge that takes in the sample completing a word. It stays high for exactly one cycle.
- R7: `word` changes only at the edge that raises `word_vld`, and holds its value between pulses.
- R8: `clr` restarts the decimation count and the slot index and discards any partial word. If `clr` coincides with the sample that would complete a word, `clr` wins: no `word_vld` follows.
- R9: A cycle with `smp_vld` low stores nothing and produces no `word_vld` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous restart of decimation and packing |
| smp_vld | input | 1 | A sample pair is present on `ch1`/`ch2` |
| ch1 | input | 12 | Channel 1 sample |
| ch2 | input | 12 | Channel 2 sample |
| mode | input | 2 | 0/3 single, 1 dual channel, 2 dual-sample interleave |
| div | input | 16 | Decimation count; keep one of `div+1` pairs |
| word | output | 96 | Last completed packed word |
| word_vld | output | 1 | One-cycle strobe for a new `word` |

## Verification
Two events can land in the same cycle: a restart from `clr`, and the kept sample that would close a word. The bench tracks its own decimation count and slot index. In every mode and decimation setting, it raises `clr` once exactly on the cycle where the closing sample is offered. It then expects no strobe and a word that does not change, and after that a fresh word built only from samples taken after the clear. Random `clr` pulses and gaps in `smp_vld` cover the same collision at other slot positions.

// File: rtl/adc_packer.sv
module adc_packer #(
  parameter int SW = 12,
  parameter int NS = 8,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_vld,
  input  logic [SW-1:0]    ch1,
  input  logic [SW-1:0]    ch2,
  input  logic [1:0]       mode,
  input  logic [DW-1:0]    div,
  output logic [SW*NS-1:0] word,
  output logic             word_vld
);
  localparam int WW   = SW * NS;
  localparam int IW   = $clog2(NS);
  localparam int HALF = NS / 2;

  logic [DW-1:0] dcnt;
  logic [IW-1:0] idx;
  logic [WW-1:0] acc, acc_nx;

  wire           keep = smp_vld && (dcnt == '0);
  wire           pair = (mode == 2'd1) || (mode == 2'd2);
  wire [IW-1:0]  last = pair ? IW'(HALF - 1) : IW'(NS - 1);
  wire           done = keep && (idx == last);

  always_comb begin
    acc_nx = acc;
    case (mode)
      2'd1: begin
        acc_nx[int'(idx) * SW +: SW]          = ch1;
        acc_nx[(int'(idx) + HALF) * SW +: SW] = ch2;
      end
      2'd2: begin
        acc_nx[(2 * int'(idx)) * SW +: SW]     = ch1;
        acc_nx[(2 * int'(idx) + 1) * SW +: SW] = ch2;
      end
      default: acc_nx[int'(idx) * SW +: SW] = ch1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt     <= '0;
      idx      <= '0;
      acc      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else if (clr) begin
      dcnt     <= '0;
      idx      <= '0;
      acc      <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= done;
      if (smp_vld) dcnt <= (dcnt == div) ? '0 : dcnt + 1'b1;
      if (keep) begin
        acc <= acc_nx;
        idx <= done ? '0 : idx + 1'b1;
      end
      if (done) word <= acc_nx;
    end
  end
endmodule

module adc_packer_chk #(
  parameter int SW = 12,
  parameter int NS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             smp_vld,
  input logic [SW*NS-1:0] word,
  input logic             word_vld
);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !word_vld);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !word_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word));
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!word_vld && word == '0));
endmodule

bind adc_packer adc_packer_chk #(.SW(SW), .NS(NS)) u_chk (.*);

// File: tb/adc_packer_tb.sv
module adc_packer_tb;
  localparam int SW = 12, NS = 8, WW = 96;

  logic clk = 0, rst_n = 0, clr = 0, smp_vld = 0;
  logic [SW-1:0] ch1 = '0, ch2 = '0;
  logic [1:0] mode = '0;
  logic [15:0] div = '0;
  logic [WW-1:0] word;
  logic word_vld;

  adc_packer u_dut (.clk, .rst_n, .clr, .smp_vld, .ch1, .ch2, .mode, .div,
                    .word, .word_vld);

  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  int mcnt = 0, midx = 0;
  logic [WW-1:0] mbuf = '0, exp_word = '0;
  logic exp_vld = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [11:0] seq = '0;

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int last_idx();
    return (mode == 2'd1 || mode == 2'd2) ? 3 : 7;
  endfunction

  task automatic step();
    @(posedge clk);
    if (clr) begin
      mcnt = 0; midx = 0; exp_vld = 0;
    end else begin
      exp_vld = 0;
      if (smp_vld) begin
        if (mcnt == 0) begin
          case (mode)
            2'd1: begin mbuf[midx*SW +: SW] = ch1; mbuf[(midx+4)*SW +: SW] = ch2; end
            2'd2: begin mbuf[2*midx*SW +: SW] = ch1; mbuf[(2*midx+1)*SW +: SW] = ch2; end
            default: mbuf[midx*SW +: SW] = ch1;
          endcase
          if (midx == last_idx()) begin
            midx = 0; exp_vld = 1; exp_word = mbuf;
          end else midx++;
        end
        mcnt = (mcnt == int'(div)) ? 0 : mcnt + 1;
      end
    end
    @(negedge clk);
    check(word_vld == exp_vld,
          clr ? "R8 strobe after clr" : (!smp_vld ? "R9 strobe after idle" : "R6/R2 strobe"),
          WW'(word_vld), WW'(exp_vld));
    check(word == exp_word,
          mode == 2'd1 ? "R4 dual word" : (mode == 2'd2 ? "R5 interleave word" : "R3 single word / R7 hold"),
          word, exp_word);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check(word_vld == 1'b0, "R1 reset strobe", WW'(word_vld), '0);
    check(word == '0, "R1 reset word", word, '0);
    rst_n = 1;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 4; d++) begin
        bit hit = 0;
        int words = 0;
        mode = 2'(m);
        div = (d == 3) ? 16'd6 : 16'(d);
        clr = 1; smp_vld = 0;
        step();
        clr = 0;
        for (int n = 0; n < 700; n++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          seq++;
          ch1 = seq;
          ch2 = seq ^ 12'hA5A;
          smp_vld = (lfsr[1:0] != 2'b00);
          clr = (lfsr[15:11] == 5'd0);
          // R8: directed clear on the cycle that would close a word
          if (!hit && words >= 2 && smp_vld && mcnt == 0 && midx == last_idx()) begin
            clr = 1; hit = 1;
          end
          step();
          if (exp_vld) words++;
        end
        clr = 0;
        check(hit, "R8 collision provoked", WW'(hit), WW'(1));
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule